// File: doc/BRIEF.md
# Interrupt Mask and Priority Unit

This unit keeps an interrupt-enable flag and an eight-bit mask, and picks the interrupt to take from an eight-bit register of line levels. A mask-set write takes its value from an accumulator byte and updates the mask and the enable flag together. A mask-read returns the mask state and the levels of the four primary lines. Separate enable and disable strobes change only the enable flag. The request flag and the restart vector are combinational from the line register and the held state, so a fetch stage can test them in the same cycle.

Line register layout: bit 0 is RST5.5, bit 1 is RST6.5, bit 2 is RST7.5, bit 3 is INTR, and bits 4 to 7 are the auxiliary lines RST1.5 to RST4.5. A half-step line x.5 restarts at address x*8+4. INTR restarts at the byte held in the external vector register, which is read as a zero-page address.

Top module: `intr_prio_unit`

## Requirements
- R1: After reset the enable flag is 0, the three primary mask bits are 1 and the four auxiliary enable bits are 0, so the read value has 4'b0111 in bits 3:0 and no request is raised.
- R2: A mask-set write with accumulator bits 0, 1 and 2 set to 1 masks RST5.5, RST6.5 and RST7.5 respectively, and a 0 unmasks the line.
- R3: A mask-set write loads accumulator bit 3 into the enable flag (1 enables, 0 disables).
- R4: A mask-set write with accumulator bits 4 to 7 set to 1 enables the auxiliary lines RST1.5 to RST4.5 (line bits 4 to 7), and a 0 blocks the line.
- R5: The enable strobe sets the enable flag and the disable strobe clears it. The disable strobe wins over the enable strobe, and a mask-set write in the same cycle wins over both.
- R6: The read value holds the enable flag in bit 3, the RST7.5/6.5/5.5 mask bits in bits 2:0, and line bits 3:0 in bits 7:4. This holds whether interrupts are enabled or not.
- R7: The vector of a selected half-step line x.5 is x*8+4: 0x0C, 0x14, 0x1C, 0x24, 0x2C, 0x34 or 0x3C.
- R8: When several unmasked lines are high, the one selected is the highest in the order RST7.5, 6.5, 5.5, 4.5, 3.5, 2.5, 1.5, INTR.
- R9: INTR has no mask bit. When it is high, no other line qualifies and interrupts are enabled, the vector is the external vector register value.
- R10: No request is raised while the enable flag is 0, and the vector output is 0 whenever no request is raised.
- R11: The request and the vector follow the line register and the vector register in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sim_we | input | 1 | Mask-set write strobe |
| acc_in | input | 8 | Accumulator value for the mask-set write |
| ei_stb | input | 1 | Enable-interrupts strobe |
| di_stb | input | 1 | Disable-interrupts strobe |
| lines_in | input | 8 | Sampled interrupt line register |
| intr_vec | input | 8 | Vector register for INTR |
| rim_data | output | 8 | Mask-read value |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Restart vector of the selected line |

## Verification
The bench writes each of the 256 accumulator values as a mask and, for each one, applies all 256 line patterns. This covers the inverted sense of the auxiliary enables: a design that applied the primary polarity there would take RST1.5 to RST4.5 when they should be blocked. It also covers every ordering between an auxiliary line and a primary line, so a priority chain with two neighbours swapped gives the wrong vector. Further checks target INTR as the lowest-priority line with its vector taken from the register, and the read value while interrupts are disabled. They also cover same-cycle collisions between the strobes and the mask-set write, where a wrong precedence leaves the enable flag in the wrong state.

// File: rtl/intr_prio_unit.sv
module intr_prio_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sim_we,
  input  logic [7:0] acc_in,
  input  logic       ei_stb,
  input  logic       di_stb,
  input  logic [7:0] lines_in,
  input  logic [7:0] intr_vec,
  output logic [7:0] rim_data,
  output logic       irq_req,
  output logic [7:0] irq_vec
);

  logic       ie;
  logic [2:0] mask_lo;
  logic [3:0] en_hi;
  logic [6:0] act;
  logic       hit;
  logic [7:0] pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie      <= 1'b0;
      mask_lo <= 3'b111;
      en_hi   <= 4'b0000;
    end else if (sim_we) begin
      en_hi   <= acc_in[7:4];
      ie      <= acc_in[3];
      mask_lo <= acc_in[2:0];
    end else if (di_stb) begin
      ie <= 1'b0;
    end else if (ei_stb) begin
      ie <= 1'b1;
    end
  end

  // act[j] is line RST(j+1).5
  assign act = {lines_in[2:0] & ~mask_lo, lines_in[7:4] & en_hi};

  always_comb begin
    hit  = lines_in[3];
    pick = intr_vec;
    for (int j = 0; j < 7; j++) begin
      if (act[j]) begin
        hit  = 1'b1;
        pick = 8'(8 * j + 12);
      end
    end
  end

  assign irq_req  = ie & hit;
  assign irq_vec  = irq_req ? pick : 8'h00;
  assign rim_data = {lines_in[3:0], ie, mask_lo};

endmodule

// File: rtl/intr_prio_chk.sv
module intr_prio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sim_we,
  input logic [7:0] acc_in,
  input logic       ei_stb,
  input logic       di_stb,
  input logic [7:0] lines_in,
  input logic [7:0] rim_data,
  input logic       irq_req,
  input logic [7:0] irq_vec
);

  // R1
  reset_state_chk: assert property (@(posedge clk) $rose(rst_n) |-> (rim_data[3:0] == 4'b0111));

  // R3
  sim_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sim_we |=> (rim_data[3:0] == $past(acc_in[3:0])));

  // R5
  di_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (di_stb && !sim_we) |=> !rim_data[3]);

  // R5
  ei_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ei_stb && !di_stb && !sim_we) |=> rim_data[3]);

  // R10
  no_req_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rim_data[3] |-> (!irq_req && irq_vec == 8'h00));

  // R8
  top_line_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rim_data[3] && lines_in[2] && !rim_data[2]) |-> (irq_req && irq_vec == 8'h3C));

endmodule

bind intr_prio_unit intr_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sim_we(sim_we), .acc_in(acc_in),
  .ei_stb(ei_stb), .di_stb(di_stb), .lines_in(lines_in),
  .rim_data(rim_data), .irq_req(irq_req), .irq_vec(irq_vec)
);

// File: tb/test_intr_prio_unit.sv
`timescale 1ns/1ps
module test_intr_prio_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sim_we = 1'b0;
  logic [7:0] acc_in = 8'h00;
  logic       ei_stb = 1'b0;
  logic       di_stb = 1'b0;
  logic [7:0] lines_in = 8'h00;
  logic [7:0] intr_vec = 8'h00;
  logic [7:0] rim_data;
  logic       irq_req;
  logic [7:0] irq_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  intr_prio_unit i_intr_prio_unit (
    .clk(clk), .rst_n(rst_n), .sim_we(sim_we), .acc_in(acc_in),
    .ei_stb(ei_stb), .di_stb(di_stb), .lines_in(lines_in),
    .intr_vec(intr_vec), .rim_data(rim_data), .irq_req(irq_req),
    .irq_vec(irq_vec)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // strobes applied at the falling edge, sampled after the next rising edge
  task automatic strobe(input bit s, input bit e, input bit d, input logic [7:0] a);
    @(negedge clk);
    sim_we = s; ei_stb = e; di_stb = d; acc_in = a;
    @(negedge clk);
    sim_we = 1'b0; ei_stb = 1'b0; di_stb = 1'b0;
    #0.5;
  endtask

  // expected selection from the stated priority list and vector rule
  function automatic logic [8:0] model(input logic [7:0] m, input logic [7:0] l,
                                       input logic [7:0] iv);
    if (!m[3]) return 9'h000;
    if (l[2] && !m[2]) return {1'b1, 8'd60};
    if (l[1] && !m[1]) return {1'b1, 8'd52};
    if (l[0] && !m[0]) return {1'b1, 8'd44};
    for (int x = 4; x >= 1; x--)
      if (l[x + 3] && m[x + 3]) return {1'b1, 8'(x * 8 + 4)};
    if (l[3]) return {1'b1, iv};
    return 9'h000;
  endfunction

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    lines_in = 8'hFF;
    #0.1;
    chk("R1 reset read", rim_data[3:0], 4'b0111);
    chk("R1 reset no request", irq_req, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;

    // R1: upper enables cleared, R5: enable strobe only
    strobe(0, 1, 0, 8'h00);
    lines_in = 8'hF0;
    #0.1;
    chk("R1 aux lines blocked", irq_req, 0);
    lines_in = 8'h08; intr_vec = 8'hA5;
    #0.1;
    chk("R9 INTR vector", irq_vec, 8'hA5);
    chk("R11 req", irq_req, 1);
    strobe(0, 1, 1, 8'h00);
    chk("R5 DI beats EI", rim_data[3], 0);
    strobe(0, 1, 0, 8'h00);
    chk("R5 EI sets", rim_data[3], 1);
    strobe(1, 1, 0, 8'h07);
    chk("R5 SIM beats EI", rim_data[3], 0);
    strobe(1, 0, 1, 8'h08);
    chk("R5 SIM beats DI", rim_data[3], 1);

    // single-line checks
    strobe(1, 0, 0, 8'hF8);
    for (int b = 0; b < 8; b++) begin
      lines_in = 8'(1 << b);
      #0.1;
      chk("R7 single line", irq_vec, (b == 3) ? 8'hA5 : (b < 3) ? (b + 5) * 8 + 4 : (b - 3) * 8 + 4);
    end
    strobe(1, 0, 0, 8'h0F);
    lines_in = 8'h07;
    #0.1;
    chk("R2 all primary masked", irq_req, 0);
    strobe(1, 0, 0, 8'h18);
    lines_in = 8'h10;
    #0.1;
    chk("R4 RST1.5 enabled", irq_vec, 8'h0C);
    strobe(1, 0, 0, 8'h00);
    lines_in = 8'h05;
    #0.1;
    chk("R3 disabled by SIM", irq_req, 0);
    chk("R6 read while disabled", rim_data, 8'h50);

    // exhaustive sweep: every mask byte against every line pattern
    for (int a = 0; a < 256; a++) begin
      intr_vec = 8'(a) ^ 8'h5A;
      strobe(1, 0, 0, 8'(a));
      for (int l = 0; l < 256; l++) begin
        logic [8:0] e;
        lines_in = 8'(l);
        #0.01;
        e = model(8'(a), 8'(l), intr_vec);
        chk("R6 read value", rim_data, {4'(l), 4'(a)});
        if (!a[3])
          chk("R10 request/vector", {irq_req, irq_vec}, 9'h000);
        else if (e[8] && e[7:0] == intr_vec && l[3] && (8'(l) & ~8'(a) & 8'h07) == 0 && (8'(l) & 8'(a) & 8'hF0) == 0)
          chk("R9 INTR", {irq_req, irq_vec}, e);
        else
          chk("R8 priority", {irq_req, irq_vec}, e);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule